// File: doc/BRIEF.md
# MESI Coherence Directory Controller

This block keeps the coherence state of every line in a small two-way set-associative data cache directory. Each way of each set holds a tag and one of four states: Modified, Exclusive, Shared or Invalid. Each set also holds one replacement bit. Core reads and writes, locked accesses and external inquire (snoop) cycles update the directory. The block decides when a bus cycle is needed and which one: a line read, a write-through, or a write-back of a modified line. It also produces the hit and modified-hit responses for snoops. Data storage and the bus protocol engine live elsewhere. A bus cycle is presented as a request and is closed by a single completion pulse. The cache-enable and write-policy inputs are sampled with that pulse.

Core requests and snoops each enter through a valid/ready pair. A core request is taken on a cycle where `core_valid` and `core_ready` are both high. While `core_valid` is high and the request has not been taken, the request fields must stay unchanged. `core_ready` is low while an operation or a write-back is outstanding. It is also low on any cycle where `snp_valid` is high, so a snoop always wins a cycle in which both arrive. A snoop is taken when `snp_valid` and `snp_ready` are both high. `snp_ready` drops while a write-back is waiting, because only one write-back can be queued. Each accepted core request produces exactly one `rsp_valid` pulse. Each accepted snoop produces exactly one `snp_rsp_valid` pulse, one cycle after acceptance.

Addresses are line addresses. The low `SETW` bits select the set and the upper `TAGW` bits are the tag. Line state codes are I=0, S=1, E=2, M=3. Bus operation codes on `bus_op` are 0 = line read, 1 = write-through, 2 = write-back.

Top module: `mesi_dir_ctrl`

## Requirements
- R1: A non-locked read that hits an M, E or S line leaves the state as it is. It starts no bus cycle, and `rsp_valid` rises with `rsp_hit`=1 in the cycle after acceptance.
- R2: A non-locked read miss puts a line read (`bus_op`=0) on the bus. At completion the line is installed if the request was marked cacheable and `bus_ken` is high. It is installed as E when `bus_wbwt` is high and the request's page write-through bit is low, and as S otherwise. If either the cacheable mark or `bus_ken` is low, the line stays Invalid.
- R3: A non-locked write that hits M or E leaves the line in M. It starts no bus cycle and responds in the next cycle.
- R4: A non-locked write that hits S starts a write-through (`bus_op`=1). At its completion the line becomes E if the page write-through bit was low and `bus_wbwt` is high. Otherwise it stays S. If a snoop has changed the line in the meantime, the line is left as the snoop made it.
- R5: A non-locked write miss starts a write-through and does not allocate a line.
- R6: A locked access invalidates the line it hits. If that line was M, a write-back of it is queued. A locked access starts no other bus cycle and responds in the next cycle.
- R7: A snoop that hits sets `snp_hit`. It also sets `snp_hitm` if the line was M. The line moves to I when `snp_inv` is high and to S when it is low. A snoop miss leaves both flags low.
- R8: A snoop hit on an M line queues a write-back (`bus_op`=2) of that line address.
- R9: The replacement bit of a set names the less recently used way and is updated on every hit and every fill. A read miss fills way 0 if it is invalid, else way 1 if it is invalid, else the way the bit names. A cacheable miss evicts that way at once, and queues a write-back if the way was M.
- R10: When a snoop and a core request arrive in the same cycle, the snoop is applied first and the core request waits.
- R11: A bus request keeps its operation and address until `bus_done`. The core operation's own cycle goes before a queued write-back, and no core request is taken while any bus request is up.
- R12: After reset every line is Invalid and every replacement bit is 0. Each core operation that needs the bus responds in the cycle after its `bus_done`, with `rsp_hit` showing whether the line was present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request valid |
| core_ready | output | 1 | Core request accepted this cycle when valid |
| core_write | input | 1 | 1 = write, 0 = read |
| core_lock | input | 1 | Locked access |
| core_cacheable | input | 1 | Core marks the access cacheable |
| core_pwt | input | 1 | Page write-through bit |
| core_addr | input | LAW | Line address of the request |
| rsp_valid | output | 1 | One-cycle completion pulse for a core request |
| rsp_hit | output | 1 | Line was present when the request was accepted |
| snp_valid | input | 1 | Snoop request valid |
| snp_ready | output | 1 | Snoop accepted this cycle when valid |
| snp_inv | input | 1 | Snoop invalidates on hit |
| snp_addr | input | LAW | Snoop line address |
| snp_rsp_valid | output | 1 | Snoop response pulse |
| snp_hit | output | 1 | Snoop hit a valid line |
| snp_hitm | output | 1 | Snoop hit a Modified line |
| bus_valid | output | 1 | Bus cycle requested |
| bus_op | output | 2 | 0 line read, 1 write-through, 2 write-back |
| bus_addr | output | LAW | Line address of the bus cycle |
| bus_done | input | 1 | Completion of the presented bus cycle |
| bus_ken | input | 1 | Cache enable, sampled with bus_done |
| bus_wbwt | input | 1 | 1 = write-back policy, sampled with bus_done |

## Verification
A behavioural model in the bench runs alongside the block and is compared with it every cycle. Directed sequences walk each line through every state transition. Fills are run with cache-enable and write policy in each combination, so that the E, S and no-allocate outcomes are each distinguished. Writes to S lines are done with the page bit both set and clear, which separates promotion from an ignored policy input. A set is filled past both ways to show the replacement order and a dirty eviction. A random phase then runs core traffic alongside snoops to a few colliding lines, with random bus latencies. This lands snoops inside fills and write-throughs, and on the very cycle a core request or a bus completion arrives, which checks both the snoop-first ordering and the write-back queueing.

// File: rtl/mesi_dir_pkg.sv
package mesi_dir_pkg;
  localparam int WAYS = 2;

  localparam logic [1:0] LN_I = 2'd0;
  localparam logic [1:0] LN_S = 2'd1;
  localparam logic [1:0] LN_E = 2'd2;
  localparam logic [1:0] LN_M = 2'd3;

  localparam logic [1:0] BOP_READ  = 2'd0;
  localparam logic [1:0] BOP_WTHRU = 2'd1;
  localparam logic [1:0] BOP_WBACK = 2'd2;

  typedef enum logic [1:0] {CT_IDLE, CT_READ, CT_WTHRU} ctl_st_e;

  // state granted by a fill or by a completed write-through
  function automatic logic [1:0] policy_state(logic wbwt, logic pwt);
    return (wbwt && !pwt) ? LN_E : LN_S;
  endfunction

  function automatic logic [1:0] snoop_next(logic [1:0] cur, logic inv);
    if (cur == LN_I) return LN_I;
    return inv ? LN_I : LN_S;
  endfunction
endpackage

// File: rtl/mesi_way_lookup.sv
module mesi_way_lookup import mesi_dir_pkg::*; #(
  parameter int TAGW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WAYS-1:0][1:0]      set_st,
  input  logic [WAYS-1:0][TAGW-1:0] set_tag,
  input  logic [TAGW-1:0]           tag,
  output logic                      hit,
  output logic                      hit_way
);
  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = (set_st[w] != LN_I) && (set_tag[w] == tag);
  end

  assign hit     = |hv;
  assign hit_way = hv[1];

  // a tag is never installed twice in one set (fills only follow misses)
  assert_single_way_R9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hv));
endmodule

// File: rtl/mesi_victim.sv
module mesi_victim import mesi_dir_pkg::*; (
  input  logic [WAYS-1:0][1:0] set_st,
  input  logic                 lru,
  output logic                 way
);
  always_comb begin
    if (set_st[0] == LN_I)      way = 1'b0;
    else if (set_st[1] == LN_I) way = 1'b1;
    else                        way = lru;
  end
endmodule

// File: rtl/mesi_dir_ctrl.sv
module mesi_dir_ctrl import mesi_dir_pkg::*; #(
  parameter  int SETS = 16,
  parameter  int TAGW = 8,
  localparam int SETW = $clog2(SETS),
  localparam int LAW  = TAGW + SETW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           core_valid,
  output logic           core_ready,
  input  logic           core_write,
  input  logic           core_lock,
  input  logic           core_cacheable,
  input  logic           core_pwt,
  input  logic [LAW-1:0] core_addr,
  output logic           rsp_valid,
  output logic           rsp_hit,
  input  logic           snp_valid,
  output logic           snp_ready,
  input  logic           snp_inv,
  input  logic [LAW-1:0] snp_addr,
  output logic           snp_rsp_valid,
  output logic           snp_hit,
  output logic           snp_hitm,
  output logic           bus_valid,
  output logic [1:0]     bus_op,
  output logic [LAW-1:0] bus_addr,
  input  logic           bus_done,
  input  logic           bus_ken,
  input  logic           bus_wbwt
);
  logic [1:0]      st_q  [SETS][WAYS];
  logic [1:0]      st_d  [SETS][WAYS];
  logic [TAGW-1:0] tag_q [SETS][WAYS];
  logic [TAGW-1:0] tag_d [SETS][WAYS];
  logic [SETS-1:0] lru_q, lru_d;

  ctl_st_e         ct_q, ct_d;
  logic            wb_pend_q, wb_set;
  logic [LAW-1:0]  wb_addr_q, wb_addr_n;
  logic [LAW-1:0]  op_addr_q;
  logic            op_way_q, op_hit_q, op_cache_q, op_pwt_q;
  logic            rsp_v_d, rsp_valid_q, rsp_hit_q;
  logic            snp_rsp_q, snp_hit_q, snp_hitm_q;

  logic [SETW-1:0] c_set, s_set, o_set;
  logic [TAGW-1:0] c_tag, s_tag, o_tag;
  assign c_set = core_addr[SETW-1:0];
  assign c_tag = core_addr[LAW-1:SETW];
  assign s_set = snp_addr[SETW-1:0];
  assign s_tag = snp_addr[LAW-1:SETW];
  assign o_set = op_addr_q[SETW-1:0];
  assign o_tag = op_addr_q[LAW-1:SETW];

  logic [WAYS-1:0][1:0]      c_set_st, s_set_st;
  logic [WAYS-1:0][TAGW-1:0] c_set_tag, s_set_tag;
  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign c_set_st[w]  = st_q[c_set][w];
    assign c_set_tag[w] = tag_q[c_set][w];
    assign s_set_st[w]  = st_q[s_set][w];
    assign s_set_tag[w] = tag_q[s_set][w];
  end

  logic c_hit, c_way, s_hit, s_way, v_way;
  mesi_way_lookup #(.TAGW(TAGW)) u_core_lk (
    .clk(clk), .rst_n(rst_n), .set_st(c_set_st), .set_tag(c_set_tag),
    .tag(c_tag), .hit(c_hit), .hit_way(c_way));
  mesi_way_lookup #(.TAGW(TAGW)) u_snp_lk (
    .clk(clk), .rst_n(rst_n), .set_st(s_set_st), .set_tag(s_set_tag),
    .tag(s_tag), .hit(s_hit), .hit_way(s_way));
  mesi_victim u_victim (.set_st(c_set_st), .lru(lru_q[c_set]), .way(v_way));

  logic [1:0] c_st, s_st;
  assign c_st = st_q[c_set][c_way];
  assign s_st = st_q[s_set][s_way];

  // handshakes: snoop wins the cycle, one write-back may be queued
  logic snp_fire, core_fire, op_done, wb_done;
  assign snp_ready  = !wb_pend_q;
  assign snp_fire   = snp_valid && snp_ready;
  assign core_ready = (ct_q == CT_IDLE) && !wb_pend_q && !snp_valid;
  assign core_fire  = core_valid && core_ready;

  // the core's own cycle is presented ahead of a queued write-back
  assign bus_valid = (ct_q != CT_IDLE) || wb_pend_q;
  assign bus_op    = (ct_q == CT_READ)  ? BOP_READ  :
                     (ct_q == CT_WTHRU) ? BOP_WTHRU : BOP_WBACK;
  assign bus_addr  = (ct_q == CT_IDLE) ? wb_addr_q : op_addr_q;
  assign op_done   = bus_done && (ct_q != CT_IDLE);
  assign wb_done   = bus_done && (ct_q == CT_IDLE) && wb_pend_q;

  always_comb begin
    st_d      = st_q;
    tag_d     = tag_q;
    lru_d     = lru_q;
    ct_d      = ct_q;
    wb_set    = 1'b0;
    wb_addr_n = wb_addr_q;
    rsp_v_d   = 1'b0;
    // 1) snoop
    if (snp_fire && s_hit) begin
      st_d[s_set][s_way] = snoop_next(s_st, snp_inv);
      if (s_st == LN_M) begin
        wb_set    = 1'b1;
        wb_addr_n = snp_addr;
      end
    end
    // 2) bus completion of the outstanding core operation (sees post-snoop state)
    if (op_done) begin
      ct_d    = CT_IDLE;
      rsp_v_d = 1'b1;
      if (ct_q == CT_READ && op_cache_q && bus_ken) begin
        st_d[o_set][op_way_q]  = policy_state(bus_wbwt, op_pwt_q);
        tag_d[o_set][op_way_q] = o_tag;
        lru_d[o_set]           = ~op_way_q;
      end else if (ct_q == CT_WTHRU && op_hit_q && st_d[o_set][op_way_q] == LN_S &&
                   tag_d[o_set][op_way_q] == o_tag) begin
        st_d[o_set][op_way_q] = policy_state(bus_wbwt, op_pwt_q);
      end
    end
    // 3) new core request (never in the same cycle as a snoop or completion)
    if (core_fire) begin
      if (core_lock) begin
        rsp_v_d = 1'b1;
        if (c_hit) begin
          st_d[c_set][c_way] = LN_I;
          if (c_st == LN_M) begin
            wb_set    = 1'b1;
            wb_addr_n = core_addr;
          end
        end
      end else if (c_hit) begin
        lru_d[c_set] = ~c_way;
        if (core_write && c_st == LN_S) begin
          ct_d = CT_WTHRU;
        end else begin
          rsp_v_d = 1'b1;
          if (core_write) st_d[c_set][c_way] = LN_M;
        end
      end else if (core_write) begin
        ct_d = CT_WTHRU;
      end else begin
        ct_d = CT_READ;
        if (core_cacheable) begin
          if (st_q[c_set][v_way] == LN_M) begin
            wb_set    = 1'b1;
            wb_addr_n = {tag_q[c_set][v_way], c_set};
          end
          st_d[c_set][v_way] = LN_I;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        for (int w = 0; w < WAYS; w++) begin
          st_q[i][w]  <= LN_I;
          tag_q[i][w] <= '0;
        end
      end
      lru_q       <= '0;
      ct_q        <= CT_IDLE;
      wb_pend_q   <= 1'b0;
      wb_addr_q   <= '0;
      op_addr_q   <= '0;
      op_way_q    <= 1'b0;
      op_hit_q    <= 1'b0;
      op_cache_q  <= 1'b0;
      op_pwt_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      snp_rsp_q   <= 1'b0;
      snp_hit_q   <= 1'b0;
      snp_hitm_q  <= 1'b0;
    end else begin
      st_q        <= st_d;
      tag_q       <= tag_d;
      lru_q       <= lru_d;
      ct_q        <= ct_d;
      wb_pend_q   <= wb_set || (wb_pend_q && !wb_done);
      if (wb_set) wb_addr_q <= wb_addr_n;
      if (core_fire) begin
        op_addr_q  <= core_addr;
        op_way_q   <= c_hit ? c_way : v_way;
        op_hit_q   <= c_hit;
        op_cache_q <= core_cacheable;
        op_pwt_q   <= core_pwt;
      end
      rsp_valid_q <= rsp_v_d;
      rsp_hit_q   <= core_fire ? c_hit : op_hit_q;
      snp_rsp_q   <= snp_fire;
      snp_hit_q   <= snp_fire && s_hit;
      snp_hitm_q  <= snp_fire && s_hit && (s_st == LN_M);
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign snp_rsp_valid = snp_rsp_q;
  assign snp_hit       = snp_hit_q;
  assign snp_hitm      = snp_hitm_q;

  assert_hitm_with_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hitm |-> (snp_hit && snp_rsp_valid));
  assert_read_hit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (core_fire && !core_write && !core_lock && c_hit) |=> (!bus_valid && rsp_valid && rsp_hit));
  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_op) && $stable(bus_addr)));
  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> !bus_valid);
  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !core_fire);
  assert_done_responds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_done && bus_op != BOP_WBACK) |=> rsp_valid);
  assert_wb_queued_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hitm |-> (bus_valid && !snp_ready));
endmodule

// File: tb/sim_mesi_dir_ctrl.sv
module sim_mesi_dir_ctrl;
  localparam int SETS = 16;
  localparam int TAGW = 8;
  localparam int LAW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_valid = 0, core_write = 0, core_lock = 0, core_cacheable = 0, core_pwt = 0;
  logic [LAW-1:0] core_addr = '0;
  logic snp_valid = 0, snp_inv = 0;
  logic [LAW-1:0] snp_addr = '0;
  logic bus_done = 0, bus_ken = 0, bus_wbwt = 0;
  logic core_ready, rsp_valid, rsp_hit, snp_ready, snp_rsp_valid, snp_hit, snp_hitm, bus_valid;
  logic [1:0] bus_op;
  logic [LAW-1:0] bus_addr;

  always #10 clk = ~clk;  // 50 MHz

  mesi_dir_ctrl #(.SETS(SETS), .TAGW(TAGW)) u0 (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
    .core_write(core_write), .core_lock(core_lock), .core_cacheable(core_cacheable),
    .core_pwt(core_pwt), .core_addr(core_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .snp_rsp_valid(snp_rsp_valid), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr), .bus_done(bus_done),
    .bus_ken(bus_ken), .bus_wbwt(bus_wbwt));

  int vectors = 0, miscmp = 0, cycles = 0;
  string phase = "R12 reset state";
  bit started = 0;

  // configuration of the bus responder
  int  cfg_lat = 1;
  bit  cfg_ken = 1, cfg_wbwt = 1, cfg_rand = 0;

  // ---------------- behavioural reference model ----------------
  int m_st  [SETS][2];
  int m_tag [SETS][2];
  int m_lru [SETS];
  int m_busy;            // 0 idle, 1 line read, 2 write-through
  bit m_wb;
  int m_wbaddr, m_opaddr, m_opway;
  bit m_ophit, m_opcache, m_oppwt;
  bit m_rspv, m_rsph, m_snpv, m_hit, m_hitm;

  function automatic int find_way(int addr);
    int s = addr % SETS, t = addr / SETS;
    for (int w = 0; w < 2; w++) if (m_st[s][w] != 0 && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        m_lru[i] = 0;
        for (int w = 0; w < 2; w++) begin m_st[i][w] = 0; m_tag[i][w] = 0; end
      end
      m_busy = 0; m_wb = 0; m_wbaddr = 0; m_opaddr = 0; m_opway = 0;
      m_ophit = 0; m_opcache = 0; m_oppwt = 0;
      m_rspv = 0; m_rsph = 0; m_snpv = 0; m_hit = 0; m_hitm = 0;
    end else begin
      bit sfire, cfire, done_any, nrsph;
      int a, s, w, v;
      sfire    = snp_valid && !m_wb;
      cfire    = core_valid && m_busy == 0 && !m_wb && !snp_valid;
      done_any = bus_done && (m_busy != 0 || m_wb);
      m_rspv = 0; nrsph = m_ophit; m_snpv = sfire; m_hit = 0; m_hitm = 0;
      if (sfire) begin
        a = int'(snp_addr); s = a % SETS; w = find_way(a);
        if (w >= 0) begin
          m_hit = 1;
          if (m_st[s][w] == 3) begin m_hitm = 1; m_wb = 1; m_wbaddr = a; end
          m_st[s][w] = snp_inv ? 0 : 1;
        end
      end
      if (done_any) begin
        if (m_busy != 0) begin
          s = m_opaddr % SETS;
          if (m_busy == 1 && m_opcache && bus_ken) begin
            m_st[s][m_opway]  = (bus_wbwt && !m_oppwt) ? 2 : 1;
            m_tag[s][m_opway] = m_opaddr / SETS;
            m_lru[s] = 1 - m_opway;
          end else if (m_busy == 2 && m_ophit && m_st[s][m_opway] == 1)
            m_st[s][m_opway] = (bus_wbwt && !m_oppwt) ? 2 : 1;
          m_busy = 0; m_rspv = 1; nrsph = m_ophit;
        end else m_wb = 0;
      end
      if (cfire) begin
        a = int'(core_addr); s = a % SETS; w = find_way(a);
        m_opaddr = a; m_opcache = core_cacheable; m_oppwt = core_pwt; m_ophit = (w >= 0);
        nrsph = (w >= 0);
        if (core_lock) begin
          m_rspv = 1;
          if (w >= 0) begin
            if (m_st[s][w] == 3) begin m_wb = 1; m_wbaddr = a; end
            m_st[s][w] = 0;
          end
        end else if (w >= 0) begin
          m_lru[s] = 1 - w; m_opway = w;
          if (core_write && m_st[s][w] == 1) m_busy = 2;
          else begin
            m_rspv = 1;
            if (core_write) m_st[s][w] = 3;
          end
        end else begin
          v = (m_st[s][0] == 0) ? 0 : (m_st[s][1] == 0) ? 1 : m_lru[s];
          m_opway = v;
          if (core_write) m_busy = 2;
          else begin
            m_busy = 1;
            if (core_cacheable) begin
              if (m_st[s][v] == 3) begin m_wb = 1; m_wbaddr = m_tag[s][v] * SETS + s; end
              m_st[s][v] = 0;
            end
          end
        end
      end
      m_rsph = nrsph;
    end
  end

  // ---------------- comparison every cycle ----------------
  task automatic chk(string sig, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL [%s] %s: actual %0d expected %0d at cycle %0d", phase, sig, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (started) begin
      bit ebv;
      ebv = (m_busy != 0) || m_wb;
      chk("core_ready", int'(core_ready), int'(m_busy == 0 && !m_wb && !snp_valid));
      chk("snp_ready", int'(snp_ready), int'(!m_wb));
      chk("bus_valid", int'(bus_valid), int'(ebv));
      if (ebv) begin
        chk("bus_op", int'(bus_op), (m_busy == 1) ? 0 : (m_busy == 2) ? 1 : 2);
        chk("bus_addr", int'(bus_addr), (m_busy != 0) ? m_opaddr : m_wbaddr);
      end
      chk("rsp_valid", int'(rsp_valid), int'(m_rspv));
      if (m_rspv) chk("rsp_hit", int'(rsp_hit), int'(m_rsph));
      chk("snp_rsp_valid", int'(snp_rsp_valid), int'(m_snpv));
      chk("snp_hit", int'(snp_hit), int'(m_hit));
      chk("snp_hitm", int'(snp_hitm), int'(m_hitm));
    end
  end

  // ---------------- bus responder ----------------
  int bcnt = 0;
  always @(negedge clk) begin
    if (bus_valid && bcnt >= cfg_lat) begin
      bus_done = 1;
      bus_ken  = cfg_rand ? 1'($urandom_range(0, 3) != 0) : cfg_ken;
      bus_wbwt = cfg_rand ? 1'($urandom_range(0, 1)) : cfg_wbwt;
      bcnt = 0;
      if (cfg_rand) cfg_lat = $urandom_range(0, 4);
    end else begin
      bus_done = 0;
      bcnt = bus_valid ? bcnt + 1 : 0;
    end
  end

  // ---------------- stimulus tasks ----------------
  function automatic logic [LAW-1:0] la(int t, int s);
    return {t[TAGW-1:0], s[3:0]};
  endfunction

  task automatic core_op(bit wr, bit lk, bit ca, bit pw, int t, int s);
    @(negedge clk);
    core_valid = 1; core_write = wr; core_lock = lk; core_cacheable = ca; core_pwt = pw;
    core_addr = la(t, s);
    #1;
    while (!core_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    core_valid = 0;
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic snoop(bit inv, int t, int s);
    @(negedge clk);
    snp_valid = 1; snp_inv = inv; snp_addr = la(t, s);
    #1;
    while (!snp_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscmp++;
      $display("FAIL [%s] watchdog: actual %0d cycles expected completion", phase, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    @(posedge clk); started = 1;
    idle(3);
    rst_n = 1;
    idle(2);

    phase = "R2 read miss fills E"; cfg_ken = 1; cfg_wbwt = 1; cfg_lat = 2;
    core_op(0, 0, 1, 0, 1, 0);
    phase = "R1 read hit quiet";
    core_op(0, 0, 1, 0, 1, 0);
    phase = "R7 snoop share E";
    snoop(0, 1, 0); idle(1);
    phase = "R4 write S promotes to E";
    core_op(1, 0, 1, 0, 1, 0);
    phase = "R3 write E to M";
    core_op(1, 0, 1, 0, 1, 0);
    core_op(1, 0, 1, 0, 1, 0);
    phase = "R8 snoop hitm write-back";
    snoop(1, 1, 0); idle(6);

    phase = "R2 read miss fills S"; cfg_wbwt = 0;
    core_op(0, 0, 1, 0, 2, 1);
    phase = "R4 pwt set keeps S"; cfg_wbwt = 1;
    core_op(1, 0, 1, 1, 2, 1);
    phase = "R4 wbwt low keeps S"; cfg_wbwt = 0;
    core_op(1, 0, 1, 0, 2, 1);
    phase = "R7 snoop invalidate S";
    snoop(1, 2, 1); snoop(1, 2, 1); idle(1);
    phase = "R2 pwt fill gives S"; cfg_wbwt = 1;
    core_op(0, 0, 1, 1, 2, 1); snoop(0, 2, 1); idle(1);

    phase = "R2 ken low no allocate"; cfg_ken = 0;
    core_op(0, 0, 1, 0, 3, 2); core_op(0, 0, 1, 0, 3, 2);
    phase = "R2 uncacheable no allocate"; cfg_ken = 1;
    core_op(0, 0, 0, 0, 4, 2); core_op(0, 0, 0, 0, 4, 2);

    phase = "R5 write miss no allocate";
    core_op(1, 0, 1, 0, 5, 3); snoop(0, 5, 3); core_op(0, 0, 1, 0, 5, 3);

    phase = "R9 replacement order"; cfg_wbwt = 1;
    core_op(0, 0, 1, 0, 6, 4); core_op(0, 0, 1, 0, 7, 4);
    core_op(1, 0, 1, 0, 6, 4);
    core_op(0, 0, 1, 0, 8, 4);
    core_op(1, 0, 1, 0, 8, 4);
    core_op(0, 0, 1, 0, 7, 4);
    core_op(0, 0, 1, 0, 8, 4);
    core_op(0, 0, 1, 0, 6, 4);
    idle(4);

    phase = "R6 locked access";
    core_op(0, 0, 1, 0, 9, 5); core_op(1, 0, 1, 0, 9, 5);
    core_op(0, 1, 1, 0, 9, 5); idle(4);
    core_op(0, 1, 1, 0, 9, 5); core_op(1, 1, 1, 0, 10, 5);
    core_op(0, 0, 1, 0, 9, 5);

    phase = "R10 snoop and core same cycle";
    fork
      core_op(0, 0, 1, 0, 9, 5);
      snoop(1, 9, 5);
    join
    idle(2);

    phase = "R11 snoop during write-through"; cfg_lat = 6; cfg_wbwt = 0;
    core_op(0, 0, 1, 0, 11, 6); cfg_wbwt = 1;
    fork
      core_op(1, 0, 1, 0, 11, 6);
      begin idle(2); snoop(1, 11, 6); end
    join
    snoop(0, 11, 6);
    phase = "R11 snoop hitm during fill";
    core_op(0, 0, 1, 0, 12, 7); core_op(1, 0, 1, 0, 12, 7);
    fork
      core_op(0, 0, 1, 0, 13, 8);
      begin idle(2); snoop(0, 12, 7); end
    join
    idle(10);

    phase = "R12 random mix"; cfg_rand = 1;
    fork
      for (int i = 0; i < 400; i++) begin
        core_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 15) == 0),
                1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 3) == 0),
                $urandom_range(1, 3), $urandom_range(0, 1));
      end
      for (int i = 0; i < 300; i++) begin
        idle($urandom_range(0, 6));
        snoop(1'($urandom_range(0, 1)), $urandom_range(1, 3), $urandom_range(0, 1));
      end
    join
    idle(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule